// File: doc/BRIEF.md
# Event timer core with main counter and register decoder

This block is the register-facing core of a memory-mapped event timer. It keeps a 64-bit main counter that advances on an external tick strobe, a two-bit global control register and a read-only capability word. Three comparator channels are decoded from the register space. Each channel can raise a one-cycle interrupt pulse when the main counter reaches its comparator value, either once or periodically.

Software talks to it through a plain 32-bit port: address, write strobe, write data and read data. Read data is combinational from the address. A write takes effect at the next rising clock edge. Each channel's pulse is routed onto a vector of interrupt lines in one of two ways. In the fixed routing mode, channel 0 and channel 1 go to preset lines. Otherwise every channel uses its own 5-bit route field.

Top module: `evt_timer_core`

## Requirements
- R1: Address 0x000 reads 0x8086A201 (bits [12:8] hold channel count minus one = 2, bit 13 marks a 64-bit counter, bit 15 marks the fixed-routing capability). Address 0x004 reads the tick period, 10000000 (femtoseconds). Writes to either address change nothing.
- R2: The global control register at 0x010 keeps only write bits [1:0]: bit 0 is run and bit 1 is fixed routing. It reads back those two bits with all upper bits zero, and resets to zero.
- R3: While run is set, the main counter increases by exactly one on every clock edge with the tick strobe high, with carry from the low word into the high word. While run is clear, it holds its value.
- R4: While run is clear, the counter can be written at 0x0F0 (low word) and 0x0F4 (high word). While run is set, those writes are ignored. Setting run again resumes counting from the held value.
- R5: Channel n occupies 0x100 + n*0x20. Its config register at +0x00 stores only write mask 0x00003E4C: bit 2 is channel enable, bit 3 is periodic mode, and bits [13:9] are the route. It always reads bit 4 (periodic capable) as 1. The word at +0x04 reads 0x00FFFFFF (one bit per reachable line). The comparator is at +0x08 (low) and +0x0C (high) and resets to all ones.
- R6: When run and the channel enable are both set, the clock edge with tick high and counter equal to the comparator drives the routed interrupt high for exactly the following cycle. There is no pulse if either enable is clear.
- R7: In periodic mode, comparator writes also load the hidden period. Each firing advances the comparator by that period, so pulses repeat every period ticks.
- R8: With fixed routing off, a channel's pulse appears on the line numbered by its route field. A route value of 24 or more drives no line.
- R9: With fixed routing on, channel 0 drives line LEG0_IRQ (default 0), channel 1 drives line 8, and channel 2 still follows its route field.
- R10: Reads of undecoded addresses, of the status word at 0x020, and of channel indices above 2 (0x160 and up) return zero. Writes to undecoded addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Counter tick strobe |
| addr_i | input | 10 | Register byte address |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 24 | Registered interrupt pulse vector |

## Verification
Read data is due in the same cycle the address is presented. A register write or a counter tick becomes visible after the next rising edge. An interrupt pulse is high during the one cycle after the edge at which the tick met a matching comparator. The bench drives every input on the falling edge and samples a short time later, so each read is taken combinationally after the preceding edge. Interrupts are stepped one tick at a time and the whole vector is compared after every step, which catches early, late and doubled pulses.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CNT_W   = 64;
  localparam int unsigned ROUTE_W = 5;
  localparam int unsigned CH_SH   = 5;                 // 0x20 bytes per channel
  localparam int unsigned CHI_W   = ADDR_W - CH_SH;

  localparam logic [ADDR_W-1:0] A_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] A_GCFG   = 10'h010;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 10'h100;

  localparam logic [CH_SH-1:0] CR_CFG    = 5'h00;
  localparam logic [CH_SH-1:0] CR_CAP    = 5'h04;
  localparam logic [CH_SH-1:0] CR_CMP_LO = 5'h08;
  localparam logic [CH_SH-1:0] CR_CMP_HI = 5'h0C;

  localparam int unsigned CF_EN   = 2;
  localparam int unsigned CF_PER  = 3;
  localparam int unsigned CF_PCAP = 4;
  localparam int unsigned CF_RT   = 9;
  localparam logic [REG_W-1:0] CFG_WMASK = 32'h0000_3E4C;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (!run_i && wr_lo_i) begin
      cnt_d[REG_W-1:0] = wdata_i;
      cnt_ce = 1'b1;
    end else if (!run_i && wr_hi_i) begin
      cnt_d[CNT_W-1:REG_W] = wdata_i;
      cnt_ce = 1'b1;
    end else if (run_i && tick_i) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en_i,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               cfg_wr_i,
  input  logic               cmp_lo_wr_i,
  input  logic               cmp_hi_wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   cfg_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic               fire_o
);
  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d;
  logic             cmp_ce, per_ce, per_mode;

  assign per_mode = cfg_q[CF_PER];
  assign fire_o   = glob_en_i & tick_i & cfg_q[CF_EN] & (count_i == cmp_q);

  always_comb begin
    cmp_d  = cmp_q;
    per_d  = per_q;
    cmp_ce = 1'b0;
    per_ce = 1'b0;
    if (cmp_lo_wr_i) begin
      cmp_d[REG_W-1:0] = wdata_i;
      per_d[REG_W-1:0] = wdata_i;
      cmp_ce = 1'b1;
      per_ce = per_mode;
    end else if (cmp_hi_wr_i) begin
      cmp_d[CNT_W-1:REG_W] = wdata_i;
      per_d[CNT_W-1:REG_W] = wdata_i;
      cmp_ce = 1'b1;
      per_ce = per_mode;
    end else if (fire_o && per_mode) begin
      cmp_d  = cmp_q + per_q;
      cmp_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      if (cfg_wr_i) cfg_q <= wdata_i & CFG_WMASK;
      if (cmp_ce)   cmp_q <= cmp_d;
      if (per_ce)   per_q <= per_d;
    end
  end

  assign cfg_o   = cfg_q | (REG_W'(1) << CF_PCAP);
  assign cmp_o   = cmp_q;
  assign route_o = cfg_q[CF_RT +: ROUTE_W];
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_pkg::*;
#(
  parameter int unsigned N_CH     = 3,
  parameter int unsigned N_IRQ    = 24,
  parameter int unsigned LEG0_IRQ = 0,
  parameter int unsigned LEG1_IRQ = 8
) (
  input  logic [N_CH-1:0]         fire_i,
  input  logic                    legacy_i,
  input  logic [N_CH*ROUTE_W-1:0] route_i,
  output logic [N_IRQ-1:0]        irq_o
);
  logic [N_IRQ-1:0] per_ch [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_IRQ-1:0] hot;
    always_comb begin
      hot = '0;
      for (int i = 0; i < N_IRQ; i++) begin
        if (legacy_i && c == 0)      hot[i] = (i == int'(LEG0_IRQ));
        else if (legacy_i && c == 1) hot[i] = (i == int'(LEG1_IRQ));
        else hot[i] = (int'(route_i[c*ROUTE_W +: ROUTE_W]) == i);
      end
    end
    assign per_ch[c] = fire_i[c] ? hot : '0;
  end

  always_comb begin
    irq_o = '0;
    for (int c = 0; c < N_CH; c++) irq_o = irq_o | per_ch[c];
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_pkg::*;
#(
  parameter int unsigned N_CH      = 3,
  parameter int unsigned N_IRQ     = 24,
  parameter int unsigned LEG0_IRQ  = 0,
  parameter int unsigned LEG1_IRQ  = 8,
  parameter int unsigned PERIOD_FS = 10000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [N_IRQ-1:0]    irq_o
);
  localparam logic [REG_W-1:0] CAP_LO =
    {16'h8086, 1'b1, 1'b0, 1'b1, 5'(N_CH - 1), 8'h01};
  localparam logic [REG_W-1:0] ROUTE_CAP =
    (N_IRQ >= REG_W) ? '1 : REG_W'((64'd1 << N_IRQ) - 64'd1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // decode
  logic [ADDR_W-1:0] ch_off;
  logic [CHI_W-1:0]  ch_idx;
  logic [CH_SH-1:0]  ch_reg;
  logic              ch_area;
  assign ch_area = (addr_i >= A_CH_BASE);
  assign ch_off  = addr_i - A_CH_BASE;
  assign ch_idx  = ch_off[ADDR_W-1:CH_SH];
  assign ch_reg  = ch_off[CH_SH-1:0];

  logic gcfg_wr, cnt_lo_wr, cnt_hi_wr, cnt_wr;
  assign gcfg_wr   = wr_en_i && (addr_i == A_GCFG);
  assign cnt_lo_wr = wr_en_i && (addr_i == A_CNT_LO);
  assign cnt_hi_wr = wr_en_i && (addr_i == A_CNT_HI);
  assign cnt_wr    = cnt_lo_wr | cnt_hi_wr;

  // global control
  logic [1:0] gcfg_q, gcfg_d;
  logic       run_w, legacy_w;
  always_comb gcfg_d = gcfg_wr ? wdata_i[1:0] : gcfg_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) gcfg_q <= '0;
    else if (gcfg_wr) gcfg_q <= gcfg_d;
  end
  assign run_w    = gcfg_q[0];
  assign legacy_w = gcfg_q[1];

  logic [CNT_W-1:0] cnt_w;
  evt_counter u_cnt (
    .clk(clk), .rst_n(rst_sync_q), .run_i(run_w), .tick_i(tick_i),
    .wr_lo_i(cnt_lo_wr), .wr_hi_i(cnt_hi_wr), .wdata_i(wdata_i),
    .count_o(cnt_w)
  );

  // channels
  logic [REG_W-1:0]        ch_cfg [N_CH];
  logic [CNT_W-1:0]        ch_cmp [N_CH];
  logic [N_CH*ROUTE_W-1:0] routes;
  logic [N_CH-1:0]         fires;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic sel;
    assign sel = wr_en_i && ch_area && (ch_idx == CHI_W'(c));
    evt_channel u_ch (
      .clk(clk), .rst_n(rst_sync_q), .glob_en_i(run_w), .tick_i(tick_i),
      .count_i(cnt_w),
      .cfg_wr_i(sel && (ch_reg == CR_CFG)),
      .cmp_lo_wr_i(sel && (ch_reg == CR_CMP_LO)),
      .cmp_hi_wr_i(sel && (ch_reg == CR_CMP_HI)),
      .wdata_i(wdata_i),
      .cfg_o(ch_cfg[c]), .cmp_o(ch_cmp[c]),
      .route_o(routes[c*ROUTE_W +: ROUTE_W]),
      .fire_o(fires[c])
    );
  end

  // interrupt routing, registered
  logic [N_IRQ-1:0] irq_d, irq_q;
  evt_irq_route #(
    .N_CH(N_CH), .N_IRQ(N_IRQ), .LEG0_IRQ(LEG0_IRQ), .LEG1_IRQ(LEG1_IRQ)
  ) u_route (
    .fire_i(fires), .legacy_i(legacy_w), .route_i(routes), .irq_o(irq_d)
  );
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) irq_q <= '0;
    else             irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    if (!ch_area) begin
      case (addr_i)
        A_CAP_LO: rdata_o = CAP_LO;
        A_CAP_HI: rdata_o = REG_W'(PERIOD_FS);
        A_GCFG:   rdata_o = {30'b0, gcfg_q};
        A_CNT_LO: rdata_o = cnt_w[REG_W-1:0];
        A_CNT_HI: rdata_o = cnt_w[CNT_W-1:REG_W];
        default:  rdata_o = '0;
      endcase
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (ch_idx == CHI_W'(c)) begin
          case (ch_reg)
            CR_CFG:    rdata_o = ch_cfg[c];
            CR_CAP:    rdata_o = ROUTE_CAP;
            CR_CMP_LO: rdata_o = ch_cmp[c][REG_W-1:0];
            CR_CMP_HI: rdata_o = ch_cmp[c][CNT_W-1:REG_W];
            default:   rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_pkg::*;
#(
  parameter int unsigned      N_CH   = 3,
  parameter int unsigned      N_IRQ  = 24,
  parameter logic [REG_W-1:0] CAP_LO = 32'h8086A201
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rdata,
  input logic [N_IRQ-1:0]  irq
);
  localparam logic [ADDR_W-1:0] OOB_BASE = ADDR_W'(32'h100 + N_CH * 32'h20);

  p_cap_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CAP_LO) |-> (rdata == CAP_LO));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == $past(cnt) + 64'd1));

  p_cnt_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_wr && !tick) |=> $stable(cnt));

  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= OOB_BASE) |-> (rdata == '0));

  p_irq_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq) <= N_CH));
endmodule

bind evt_timer_core evt_timer_chk #(
  .N_CH(N_CH), .N_IRQ(N_IRQ), .CAP_LO(CAP_LO)
) u_chk (
  .clk(clk), .rst_n(rst_sync_q), .run(run_w), .tick(tick_i),
  .cnt_wr(cnt_wr), .cnt(cnt_w), .addr(addr_i), .rdata(rdata_o), .irq(irq_o)
);

// File: tb/sim_evt_timer_core.sv
`timescale 1ns/1ps
module sim_evt_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [23:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  evt_timer_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_ch_cfg(input logic [31:0] w);
    return (w & 32'h0000_3E4C) | 32'h0000_0010;
  endfunction

  function automatic logic [23:0] line(input int n);
    return 24'(1) << n;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
  endtask

  task automatic step(output logic [23:0] v);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    #1 v = irq_o;
  endtask

  task automatic set_count(input logic [31:0] hi, input logic [31:0] lo);
    wr(10'h010, 32'h0);
    wr(10'h0F0, lo);
    wr(10'h0F4, hi);
  endtask

  // ticks with counter starting at 100, comparator 103: fire expected on 4th
  task automatic run_fire(input string req, input logic [23:0] exp_vec);
    logic [23:0] v;
    for (int k = 1; k <= 4; k++) begin
      step(v);
      chk(req, {40'b0, v}, {40'b0, (k == 4) ? exp_vec : 24'h0});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, w;
    logic [63:0] exp_cnt;
    logic [23:0] v;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(10'h000, r); chk("R1 cap low", {32'b0, r}, 64'h8086A201);
    rd(10'h004, r); chk("R1 period", {32'b0, r}, 64'd10000000);
    rd(10'h010, r); chk("R2 reset cfg", {32'b0, r}, 64'h0);
    rd(10'h0F0, r); chk("R3 reset count", {32'b0, r}, 64'h0);
    rd(10'h108, r); chk("R5 reset cmp", {32'b0, r}, 64'hFFFFFFFF);
    chk("R6 reset irq", {40'b0, irq_o}, 64'h0);

    // R1: capability writes ignored
    wr(10'h000, 32'h0); wr(10'h004, 32'h1);
    rd(10'h000, r); chk("R1 cap low after write", {32'b0, r}, 64'h8086A201);
    rd(10'h004, r); chk("R1 period after write", {32'b0, r}, 64'd10000000);

    // R2: only bits [1:0] kept
    wr(10'h010, 32'hFFFF_FFFE);
    rd(10'h010, r); chk("R2 cfg mask", {32'b0, r}, 64'h2);
    wr(10'h010, 32'h0);
    rd(10'h010, r); chk("R2 cfg clear", {32'b0, r}, 64'h0);

    // R4: counter halves written while stopped (random)
    for (int i = 0; i < 6; i++) begin
      w = $urandom(); r2 = $urandom();
      set_count(r2, w);
      rd(10'h0F0, r); chk("R4 count low write", {32'b0, r}, {32'b0, w});
      rd(10'h0F4, r); chk("R4 count high write", {32'b0, r}, {32'b0, r2});
    end

    // R3: random tick pattern while running
    set_count(32'h0, 32'h0000_1000);
    exp_cnt = 64'h1000;
    wr(10'h010, 32'h1);
    for (int k = 0; k < 40; k++) begin
      tick_i = 1'($urandom_range(0, 1));
      exp_cnt = exp_cnt + {63'b0, tick_i};
      @(negedge clk);
    end
    tick_i = 1'b0;
    rd(10'h0F0, r); chk("R3 count after ticks", {32'b0, r}, {32'b0, exp_cnt[31:0]});

    // R4: write ignored while running
    wr(10'h0F0, 32'h0BAD_0BAD);
    rd(10'h0F0, r); chk("R4 write locked while running", {32'b0, r}, {32'b0, exp_cnt[31:0]});

    // R3: stopped counter holds through ticks
    wr(10'h010, 32'h0);
    for (int k = 0; k < 5; k++) step(v);
    rd(10'h0F0, r); chk("R3 hold when stopped", {32'b0, r}, {32'b0, exp_cnt[31:0]});

    // R4: resume from held value
    wr(10'h010, 32'h1);
    for (int k = 0; k < 3; k++) step(v);
    rd(10'h0F0, r); chk("R4 resume", {32'b0, r}, {32'b0, exp_cnt[31:0] + 32'd3});

    // R3: carry into high word
    set_count(32'h0, 32'hFFFF_FFFE);
    wr(10'h010, 32'h1);
    for (int k = 0; k < 3; k++) step(v);
    rd(10'h0F0, r); chk("R3 carry low", {32'b0, r}, 64'h1);
    rd(10'h0F4, r); chk("R3 carry high", {32'b0, r}, 64'h1);
    wr(10'h010, 32'h0);

    // R5: channel 2 config mask, random
    for (int i = 0; i < 8; i++) begin
      w = $urandom() & ~32'h4;
      wr(10'h140, w);
      rd(10'h140, r); chk("R5 ch cfg mask", {32'b0, r}, {32'b0, exp_ch_cfg(w)});
    end
    wr(10'h140, 32'h0);
    rd(10'h124, r); chk("R5 route cap", {32'b0, r}, 64'h00FFFFFF);
    wr(10'h148, 32'h1234_5678); wr(10'h14C, 32'h9ABC_DEF0);
    rd(10'h148, r); chk("R5 cmp low", {32'b0, r}, 64'h12345678);
    rd(10'h14C, r); chk("R5 cmp high", {32'b0, r}, 64'h9ABCDEF0);

    // R10: out of range, status, undecoded
    rd(10'h160, r); chk("R10 channel 3 cfg", {32'b0, r}, 64'h0);
    rd(10'h3E8, r); chk("R10 high channel", {32'b0, r}, 64'h0);
    rd(10'h020, r); chk("R10 status", {32'b0, r}, 64'h0);
    for (int i = 0; i < 4; i++) begin
      logic [9:0] a;
      a = 10'h030 + 10'($urandom_range(0, 15) * 8);
      wr(a, 32'hFFFF_FFFF);
      rd(a, r); chk("R10 undecoded read", {32'b0, r}, 64'h0);
      rd(10'h010, r); chk("R10 undecoded write no effect", {32'b0, r}, 64'h0);
    end

    // R6: channel enable clear -> no pulse
    wr(10'h108, 32'd103); wr(10'h10C, 32'h0);
    wr(10'h100, 32'h0000_0A00);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h1);
    run_fire("R6 channel disabled", 24'h0);

    // R6/R8: one-shot on route 5
    wr(10'h100, 32'h0000_0A04);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h1);
    run_fire("R6 R8 fire on route 5", line(5));

    // R6: global run clear, channel enabled -> no pulse, counter frozen
    set_count(32'h0, 32'd103);
    for (int k = 0; k < 3; k++) begin
      step(v); chk("R6 stopped no fire", {40'b0, v}, 64'h0);
    end

    // R8: route beyond vector drives nothing
    wr(10'h100, 32'h0000_3E04);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h1);
    run_fire("R8 route out of range", 24'h0);

    // R9: fixed routing, channel 0
    wr(10'h100, 32'h0000_0A04);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h3);
    run_fire("R9 fixed route ch0", line(0));
    wr(10'h100, 32'h0);

    // R9: fixed routing, channel 1
    wr(10'h120, 32'h0000_0A04);
    wr(10'h128, 32'd103); wr(10'h12C, 32'h0);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h3);
    run_fire("R9 fixed route ch1", line(8));

    // R9: fixed routing, channel 2 keeps its route field
    wr(10'h120, 32'h0);
    wr(10'h140, 32'h0000_0C04);
    wr(10'h148, 32'd103); wr(10'h14C, 32'h0);
    set_count(32'h0, 32'd100);
    wr(10'h010, 32'h3);
    run_fire("R9 fixed route ch2 uses field", line(6));
    wr(10'h140, 32'h0);

    // R7: periodic channel 1, period 4, route 7
    set_count(32'h0, 32'h0);
    wr(10'h120, 32'h0000_0E0C);
    wr(10'h128, 32'd4); wr(10'h12C, 32'h0);
    wr(10'h010, 32'h1);
    for (int k = 1; k <= 13; k++) begin
      step(v);
      chk("R7 periodic pulse", {40'b0, v},
          {40'b0, (k == 5 || k == 9 || k == 13) ? line(7) : 24'h0});
    end
    rd(10'h128, r); chk("R7 comparator advanced", {32'b0, r}, 64'd16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule